// File: doc/BRIEF.md
# Erasable PROM Mode Decoder Model

This block is a synthesizable behavioural model of a byte-wide, electrically programmable and light-erasable read-only memory. It lets a programmer controller be checked in simulation or on an emulation fabric. Five control inputs decide the operating mode: chip select, output strobe, program strobe, a raised programming supply flag and a high-voltage flag on address line nine. All three strobes are active low. Two digital flags stand in for the analog supply and high-voltage levels. The block either drives a byte onto its data output, together with a drive enable that models a three-state bus, or it leaves the bus undriven.

The cell array starts erased, with every bit at one. Programming can only clear bits. The model latches the address and data of a program strobe on every low cycle. It commits them when the strobe rises, but only if the strobe stayed low long enough. An erase request sweeps the whole array back to all ones, one word per clock. Reset starts the same sweep. Any control combination that no defined mode covers sets a sticky error flag.

Top module: `eprom_mode_model`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `a9_hv`=0 (read), `dq_oe` is 1 and `dq_out` equals the stored byte at `addr`, combinationally.
- R2: With `ce_n`=0, `oe_n`=1 and `vpp_hi`=0 (output disable), `dq_oe` is 0. With `ce_n`=1 and `vpp_hi`=0 (standby), `dq_oe` is 0 whatever the other inputs are.
- R3: With `vpp_hi`=1, `ce_n`=0, `oe_n`=1 and `pgm_n`=0 (program), `dq_oe` is 0. The block latches `addr` and `din` on each such cycle. When `pgm_n` is next sampled high, with `ce_n`=0 and `vpp_hi`=1 and no illegal combination, the latched values are committed to the array two clock edges later.
- R4: A program strobe held low for fewer than `MIN_PULSE` sampled cycles changes no cell. A strobe held low for exactly `MIN_PULSE` cycles does write.
- R5: With `vpp_hi`=1, `ce_n`=0, `oe_n`=0 and `pgm_n`=1 (verify), `dq_oe` is 1 and `dq_out` is the stored byte at `addr`.
- R6: With `ce_n`=1 and `vpp_hi`=1 (program inhibit), `dq_oe` is 0, and program strobe pulses change no cell.
- R7: With `a9_hv`=1, `ce_n`=0, `oe_n`=0 and `vpp_hi`=0 (identifier), `dq_oe` is 1. `dq_out` is 0x97 when `addr[0]`=0 and 0x32 when `addr[0]`=1.
- R8: A committed write stores the bitwise AND of the old byte and the written byte. For example, 0xF0 followed by 0x3C leaves 0x30.
- R9: A one-cycle `erase_req` pulse while idle raises `erase_busy` for `DEPTH` cycles. After that every byte reads 0xFF. Commits that arrive while the sweep runs are dropped.
- R10: With `ce_n`=0 and `vpp_hi`=1, the combinations `oe_n`=0 with `pgm_n`=0, or `a9_hv`=1, set `err_flag` on the next edge. The flag stays set until reset, and the array is left unchanged.
- R11: After reset, `err_flag` is 0 and `erase_busy` is 1. The array then reads all ones once the sweep ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | AW | Word address |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output strobe, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hv | input | 1 | High voltage present on address line nine |
| erase_req | input | 1 | Start a full-array erase sweep |
| din | input | 8 | Data presented during programming |
| dq_out | output | 8 | Data bus value |
| dq_oe | output | 1 | Data bus drive enable (0 = high impedance) |
| err_flag | output | 1 | Sticky illegal-control flag |
| erase_busy | output | 1 | Erase sweep in progress |

## Verification
Corruption of the latched address or data shows up at the next read or verify of the target word, and at no other time. The bench therefore reads each word back within a few cycles of its strobe release, and also reads a neighbour word that must not have moved. A pulse counter that is off by one appears only at the exact `MIN_PULSE` boundary, so lengths of `MIN_PULSE`-1 and `MIN_PULSE` are both exercised. A wrong sweep pointer leaves words that are not 0xFF after `erase_busy` drops, and the bench probes words that were programmed beforehand to catch this. A mode decode error shows up at once as a wrong `dq_oe`, or as `err_flag` set one edge too early or not at all.

// File: rtl/eprom_pkg.sv
// Shared types for the erasable PROM model.
package eprom_pkg;
    // Operating modes resolved from the control inputs.
    typedef enum logic [2:0] {
        M_STANDBY,
        M_READ,
        M_OUTDIS,
        M_PROGRAM,
        M_VERIFY,
        M_INHIBIT,
        M_SIGNATURE,
        M_ILLEGAL
    } mode_e;
endpackage

// File: rtl/eprom_mode_decode.sv
// Combinational decoder from control strobes and voltage flags to one mode.
// Assumes all strobes are active low and that the flags are already clean
// digital levels.
module eprom_mode_decode
    import eprom_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  pgm_n,
    input  logic  vpp_hi,
    input  logic  a9_hv,
    output mode_e mode
);
    // Resolve the mode. Chip select high dominates everything else.
    always_comb begin
        if (ce_n) begin
            mode = vpp_hi ? M_INHIBIT : M_STANDBY;
        end else if (!vpp_hi) begin
            if (oe_n)       mode = M_OUTDIS;
            else if (a9_hv) mode = M_SIGNATURE;
            else            mode = M_READ;
        end else begin
            if (a9_hv)                mode = M_ILLEGAL;
            else if (oe_n && !pgm_n)  mode = M_PROGRAM;
            else if (!oe_n && pgm_n)  mode = M_VERIFY;
            else if (oe_n && pgm_n)   mode = M_OUTDIS;
            else                      mode = M_ILLEGAL;
        end
    end
endmodule

// File: rtl/eprom_pulse_qual.sv
// Program pulse qualifier. It counts the cycles the program strobe stays low
// in program mode, latches address and data on every low cycle, and issues a
// one-cycle write request when the strobe rises after a long enough pulse.
// Assumes MIN_PULSE >= 1.
module eprom_pulse_qual
    import eprom_pkg::*;
#(
    parameter int AW        = 8,
    parameter int MIN_PULSE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_e         mode,
    input  logic          pgm_n,
    input  logic          ce_n,
    input  logic          vpp_hi,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    localparam int CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(MIN_PULSE);

    logic [CW-1:0] low_cnt;
    logic [AW-1:0] lat_addr;
    logic [7:0]    lat_data;
    logic          rise_ok;

    // Strobe is back high under a legal raised-supply, selected condition.
    assign rise_ok = pgm_n && !ce_n && vpp_hi && (mode != M_ILLEGAL);

    // Count low cycles, latch the operands, and fire the write on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            lat_addr <= '0;
            lat_data <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (mode == M_PROGRAM) begin
                if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
                lat_addr <= addr;
                lat_data <= din;
            end else begin
                if (low_cnt == CNT_MAX && rise_ok) begin
                    wr_en   <= 1'b1;
                    wr_addr <= lat_addr;
                    wr_data <= lat_data;
                end
                low_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/eprom_cell_array.sv
// Cell array that clears only toward zero, with a word-per-cycle erase sweep.
// Assumes DEPTH is a power of two. Reset starts a sweep, so the contents are
// defined once erase_busy falls. Writes that arrive during a sweep are dropped.
module eprom_cell_array #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase_req,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] sweep_ptr;

    // Sequence the erase sweep pointer and the busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b1;
            sweep_ptr <= '0;
        end else if (busy) begin
            sweep_ptr <= sweep_ptr + 1'b1;
            if (sweep_ptr == LAST) busy <= 1'b0;
        end else if (erase_req) begin
            busy      <= 1'b1;
            sweep_ptr <= '0;
        end
    end

    // Update cells: the sweep sets words to ones, a program ANDs into them.
    always_ff @(posedge clk) begin
        if (busy) begin
            mem[sweep_ptr] <= 8'hFF;
        end else if (wr_en) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    // Asynchronous read port.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eprom_mode_model.sv
// Top level of the erasable PROM model. It decodes the mode, qualifies
// program pulses, holds the cell array, multiplexes array or identifier
// bytes onto the bus, and keeps the sticky illegal-control flag.
// Assumes synchronous use: all controls are sampled on clk.
module eprom_mode_model
    import eprom_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int MIN_PULSE = 4,
    parameter logic [7:0] MFG_CODE = 8'h97,
    parameter logic [7:0] DEV_CODE = 8'h32,
    parameter int AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          pgm_n,
    input  logic          vpp_hi,
    input  logic          a9_hv,
    input  logic          erase_req,
    input  logic [7:0]    din,
    output logic [7:0]    dq_out,
    output logic          dq_oe,
    output logic          err_flag,
    output logic          erase_busy
);
    mode_e         mode;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [7:0]    cell_byte;

    eprom_mode_decode i_decode (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .pgm_n  (pgm_n),
        .vpp_hi (vpp_hi),
        .a9_hv  (a9_hv),
        .mode   (mode)
    );

    eprom_pulse_qual #(.AW(AW), .MIN_PULSE(MIN_PULSE)) i_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .pgm_n   (pgm_n),
        .ce_n    (ce_n),
        .vpp_hi  (vpp_hi),
        .addr    (addr),
        .din     (din),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    eprom_cell_array #(.DEPTH(DEPTH), .AW(AW)) i_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_req (erase_req),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (addr),
        .rd_data   (cell_byte),
        .busy      (erase_busy)
    );

    // Pick the bus value and drive enable for the current mode.
    always_comb begin
        dq_oe  = 1'b0;
        dq_out = 8'h00;
        case (mode)
            M_READ, M_VERIFY: begin
                dq_oe  = 1'b1;
                dq_out = cell_byte;
            end
            M_SIGNATURE: begin
                dq_oe  = 1'b1;
                dq_out = addr[0] ? DEV_CODE : MFG_CODE;
            end
            default: begin
                dq_oe  = 1'b0;
                dq_out = 8'h00;
            end
        endcase
    end

    // Latch any illegal control combination until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                 err_flag <= 1'b0;
        else if (mode == M_ILLEGAL) err_flag <= 1'b1;
    end
endmodule

// File: rtl/eprom_mode_checker.sv
// Port-level properties of the PROM model, bound to the top module.
module eprom_mode_checker #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          ce_n,
    input logic          oe_n,
    input logic          pgm_n,
    input logic          vpp_hi,
    input logic          a9_hv,
    input logic [7:0]    dq_out,
    input logic          dq_oe,
    input logic          err_flag
);
    p_standby_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !vpp_hi) |-> !dq_oe);

    p_program_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && vpp_hi && oe_n && !pgm_n) |-> !dq_oe);

    p_inhibit_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && vpp_hi) |-> !dq_oe);

    p_sig_mfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !vpp_hi && a9_hv && !addr[0]) |-> (dq_oe && dq_out == 8'h97));

    p_sig_dev_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !vpp_hi && a9_hv && addr[0]) |-> (dq_oe && dq_out == 8'h32));

    p_illegal_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && vpp_hi && ((!oe_n && !pgm_n) || a9_hv)) |=> err_flag);

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
endmodule

bind eprom_mode_model eprom_mode_checker #(.AW(AW)) i_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .pgm_n    (pgm_n),
    .vpp_hi   (vpp_hi),
    .a9_hv    (a9_hv),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .err_flag (err_flag)
);

// File: tb/test_eprom_mode_model.sv
`timescale 1ns/1ps
module test_eprom_mode_model;
    localparam int DEPTH = 256;
    localparam int MINP  = 4;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ce_n, oe_n, pgm_n, vpp_hi, a9_hv, erase_req;
    logic [7:0]    din;
    logic [7:0]    dq_out;
    logic          dq_oe, err_flag, erase_busy;
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    eprom_mode_model #(.DEPTH(DEPTH), .MIN_PULSE(MINP)) i_eprom_mode_model (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .pgm_n(pgm_n), .vpp_hi(vpp_hi), .a9_hv(a9_hv), .erase_req(erase_req),
        .din(din), .dq_out(dq_out), .dq_oe(dq_oe), .err_flag(err_flag),
        .erase_busy(erase_busy)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        ce_n = 1; oe_n = 1; pgm_n = 1; vpp_hi = 0; a9_hv = 0; erase_req = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        addr = a; ce_n = 0; oe_n = 0; pgm_n = 1; vpp_hi = 0; a9_hv = 0;
        #1; d = dq_out; oe = dq_oe;
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [7:0] d, input int len, input logic cen);
        @(negedge clk);
        addr = a; din = d; ce_n = cen; oe_n = 1; vpp_hi = 1; a9_hv = 0; pgm_n = 0;
        repeat (len) @(negedge clk);
        pgm_n = 1;
        repeat (3) @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        logic [7:0] d; logic oe;
        rst_n = 0; idle(); repeat (3) @(negedge clk);
        rst_n = 1; #1;
        chk("R11 err_flag after reset", {7'd0, err_flag}, 8'h00);
        chk("R11 busy after reset", {7'd0, erase_busy}, 8'h01);
        repeat (DEPTH + 4) @(negedge clk);
        chk("R11 sweep ended", {7'd0, erase_busy}, 8'h00);
        rd(8'd0, d, oe);   chk("R11/R1 erased word 0", d, 8'hFF);
        chk("R1 read drives", {7'd0, oe}, 8'h01);
        rd(8'd255, d, oe); chk("R11 erased last word", d, 8'hFF);
    endtask

    task automatic t_program();
        logic [7:0] d; logic oe;
        @(negedge clk);
        addr = 8'd5; din = 8'hA5; ce_n = 0; oe_n = 1; vpp_hi = 1; pgm_n = 0; #1;
        chk("R3 bus idle while programming", {7'd0, dq_oe}, 8'h00);
        idle();
        prog(8'd5, 8'hA5, MINP, 1'b0);
        rd(8'd5, d, oe); chk("R3/R1 programmed word", d, 8'hA5);
        rd(8'd6, d, oe); chk("R3 neighbour untouched", d, 8'hFF);
    endtask

    task automatic t_short_pulse();
        logic [7:0] d; logic oe;
        prog(8'd12, 8'h00, MINP - 1, 1'b0);
        rd(8'd12, d, oe); chk("R4 short pulse no write", d, 8'hFF);
        prog(8'd13, 8'h00, MINP, 1'b0);
        rd(8'd13, d, oe); chk("R4 exact minimum writes", d, 8'h00);
    endtask

    task automatic t_and_write();
        logic [7:0] d; logic oe;
        prog(8'd9, 8'hF0, MINP + 2, 1'b0);
        prog(8'd9, 8'h3C, MINP, 1'b0);
        rd(8'd9, d, oe); chk("R8 AND of writes", d, 8'h30);
        prog(8'd9, 8'hFF, MINP, 1'b0);
        rd(8'd9, d, oe); chk("R8 ones cannot return", d, 8'h30);
    endtask

    task automatic t_verify();
        @(negedge clk);
        addr = 8'd5; ce_n = 0; oe_n = 0; pgm_n = 1; vpp_hi = 1; a9_hv = 0; #1;
        chk("R5 verify drives", {7'd0, dq_oe}, 8'h01);
        chk("R5 verify data", dq_out, 8'hA5);
        idle();
    endtask

    task automatic t_inhibit();
        logic [7:0] d; logic oe;
        @(negedge clk);
        addr = 8'd20; din = 8'h00; ce_n = 1; oe_n = 0; vpp_hi = 1; pgm_n = 0; #1;
        chk("R6 inhibit high impedance", {7'd0, dq_oe}, 8'h00);
        idle();
        prog(8'd20, 8'h00, MINP + 3, 1'b1);
        rd(8'd20, d, oe); chk("R6 inhibit keeps cell", d, 8'hFF);
    endtask

    task automatic t_disable();
        @(negedge clk);
        addr = 8'd5; ce_n = 1; oe_n = 0; pgm_n = 0; vpp_hi = 0; a9_hv = 1; #1;
        chk("R2 standby high impedance", {7'd0, dq_oe}, 8'h00);
        @(negedge clk);
        ce_n = 0; oe_n = 1; pgm_n = 1; a9_hv = 0; #1;
        chk("R2 output disable high impedance", {7'd0, dq_oe}, 8'h00);
        idle();
    endtask

    task automatic t_signature();
        @(negedge clk);
        addr = 8'd0; ce_n = 0; oe_n = 0; pgm_n = 1; vpp_hi = 0; a9_hv = 1; #1;
        chk("R7 manufacturer code", dq_out, 8'h97);
        chk("R7 drives", {7'd0, dq_oe}, 8'h01);
        @(negedge clk); addr = 8'd1; #1;
        chk("R7 device code", dq_out, 8'h32);
        @(negedge clk); addr = 8'd5; #1;
        chk("R7 bit0 selects over array", dq_out, 8'h32);
        idle();
    endtask

    task automatic t_erase();
        logic [7:0] d; logic oe;
        @(negedge clk); erase_req = 1;
        @(negedge clk); erase_req = 0; #1;
        chk("R9 busy raised", {7'd0, erase_busy}, 8'h01);
        repeat (DEPTH - 2) @(negedge clk);
        #1; chk("R9 still busy", {7'd0, erase_busy}, 8'h01);
        repeat (4) @(negedge clk);
        #1; chk("R9 busy dropped", {7'd0, erase_busy}, 8'h00);
        rd(8'd5, d, oe);  chk("R9 erased word 5", d, 8'hFF);
        rd(8'd9, d, oe);  chk("R9 erased word 9", d, 8'hFF);
        rd(8'd13, d, oe); chk("R9 erased word 13", d, 8'hFF);
    endtask

    task automatic t_illegal();
        logic [7:0] d; logic oe;
        idle(); #1;
        chk("R10 flag clear before", {7'd0, err_flag}, 8'h00);
        @(negedge clk);
        addr = 8'd30; din = 8'h00; ce_n = 0; oe_n = 0; pgm_n = 0; vpp_hi = 1;
        @(negedge clk); #1;
        chk("R10 flag set", {7'd0, err_flag}, 8'h01);
        idle(); repeat (4) @(negedge clk); #1;
        chk("R10 flag sticky", {7'd0, err_flag}, 8'h01);
        rd(8'd30, d, oe); chk("R10 array unchanged", d, 8'hFF);
    endtask

    initial begin
        addr = '0; din = '0;
        t_reset();
        t_program();
        t_short_pulse();
        t_and_write();
        t_verify();
        t_inhibit();
        t_disable();
        t_signature();
        t_erase();
        t_illegal();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule